// File: doc/BRIEF.md
# Three-wire serial EEPROM slave controller

This block is the device side of a three-wire serial EEPROM. A host selects it with a chip-select line, clocks it with a serial clock and feeds it through a data-in line. The block answers on a single data-out line. All three inputs are sampled by the system clock. Their edges are detected inside the block, so the serial clock must be several times slower than the system clock. A frame starts with a start bit of 1. Then come a two-bit opcode, the word address and, for the data-writing commands, one data word. The block decodes a read, a single-word write, a single-word erase and four extended commands. The extended commands are: enable programming, disable programming, write one word to the whole array, and erase the whole array.

Every modifying command is gated by a programming-enable latch. The latch comes up cleared. A programming command takes effect when chip select falls after a complete frame. It then occupies the block for a self-timed interval counted in system clocks. While chip select is held high after a launch, data-out reports the state of that interval. An SK rising edge with data-in high, while chip select is high, drops this report. The same edge also counts as a start bit.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset the programming-enable latch is clear, data-out is 0 and the block is idle, so a single-word write issued without a new enable leaves memory unchanged.
- R2: While the latch is clear, single-word write, erase, whole-array write and whole-array erase leave every stored word unchanged and raise no status on data-out.
- R3: The extended command with top address bits 11 sets the latch and the one with 00 clears it; read returns stored data whichever state the latch is in.
- R4: A read frame (opcode 10) puts a dummy 0 on data-out after the last address bit, then the addressed word MSB first, one bit per SK rising edge.
- R5: A write frame (opcode 01, then address, then WORD_W data bits) launches on the fall of chip select. With chip select high, data-out is 0 for the max(PROG_CYCLES, 2^ADDR_W) system clocks of the interval and 1 afterwards.
- R6: An SK rising edge with chip select and data-in high clears the status report, so data-out goes to 0. If the block is not busy, the same edge is taken as the start bit of a new frame.
- R7: The extended command with top address bits 01 takes a data word, ignores the rest of the address field, and writes that word to every location.
- R8: Opcode 11 sets the addressed word to all ones; the extended command with top address bits 10 sets every word to all ones.
- R9: A frame sent while the programming interval is running is ignored entirely.
- R10: An SK rising edge after the last frame bit and before chip select falls cancels the command.
- R11: Zeros clocked in before the start bit are ignored.
- R12: Data-out is 0 whenever chip select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data in |
| dout | output | 1 | Serial data out: read data or ready/busy status |

## Verification
Clearing the ready report and capturing a start bit happen on the same SK rising edge. The bench provokes this by raising chip select after a write, waiting for data-out to show 1, and then clocking a full read frame without dropping chip select. The first data-in 1 of that frame both ends the status report and opens the frame. The result is judged by the returned dummy bit and word. A second case sends a complete frame while the interval runs: the clearing edge is present but the start bit must be refused. Memory read afterwards must show no change.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OP, ST_ADDR, ST_DATA, ST_READ, ST_ARM, ST_DROP
  } mw_state_e;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_READ, CMD_WRITE, CMD_ERASE,
    CMD_EWEN, CMD_EWDS, CMD_WRAL, CMD_ERAL
  } mw_cmd_e;

  // opcode and the two leading address bits give the command
  function automatic mw_cmd_e mw_decode(input logic [1:0] op, input logic [1:0] ext);
    mw_cmd_e c;
    case (op)
      2'b10:   c = CMD_READ;
      2'b01:   c = CMD_WRITE;
      2'b11:   c = CMD_ERASE;
      default: begin
        case (ext)
          2'b00:   c = CMD_EWDS;
          2'b01:   c = CMD_WRAL;
          2'b10:   c = CMD_ERAL;
          default: c = CMD_EWEN;
        endcase
      end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/mw_mem.sv
module mw_mem #(
  parameter int ADDR_W = 7,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int ADDR_W      = 7,
  parameter int PROG_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              all_words,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              busy,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LEN   = (PROG_CYCLES > DEPTH) ? PROG_CYCLES : DEPTH;
  localparam int CW    = $clog2(LEN + 1);

  logic [CW-1:0]     cnt;
  logic              all_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      all_q  <= 1'b0;
      addr_q <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      cnt    <= '0;
      all_q  <= all_words;
      addr_q <= addr_in;
    end else if (busy) begin
      if (cnt == CW'(LEN - 1)) busy <= 1'b0;
      else                     cnt  <= cnt + 1'b1;
    end
  end

  // single word: first cycle; whole array: one word per cycle
  assign wr_en   = busy && (all_q ? (cnt < CW'(DEPTH)) : (cnt == '0));
  assign wr_addr = all_q ? cnt[ADDR_W-1:0] : addr_q;
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave #(
  parameter int ADDR_W      = 7,
  parameter int WORD_W      = 16,
  parameter int PROG_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic dout
);
  import mw_pkg::*;

  localparam int MAXF  = (ADDR_W > WORD_W) ? ADDR_W : WORD_W;
  localparam int CNT_W = $clog2(MAXF + 1);

  logic cs_q, cs_d, sk_q, sk_d, di_q;
  logic sk_rise, cs_fall;

  mw_state_e         st;
  logic [CNT_W-1:0]  bcnt;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_sr, addr_next;
  logic [WORD_W-1:0] data_sr, rd_sr, fill_q, mem_q;
  mw_cmd_e           cmd_q, cmd_now;
  logic              wen_q, status_en, rd_load;
  logic              last_addr, rd_en, launch, prog_cmd, prog_go, all_cmd;
  logic              busy, mem_we;
  logic [ADDR_W-1:0] mem_wa;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q <= 1'b0; cs_d <= 1'b0; sk_q <= 1'b0; sk_d <= 1'b0; di_q <= 1'b0;
    end else begin
      cs_q <= cs; cs_d <= cs_q; sk_q <= sk; sk_d <= sk_q; di_q <= di;
    end
  end

  assign sk_rise   = sk_q & ~sk_d;
  assign cs_fall   = cs_d & ~cs_q;
  assign addr_next = {addr_sr[ADDR_W-2:0], di_q};
  assign last_addr = (st == ST_ADDR) && sk_rise && (bcnt == CNT_W'(ADDR_W - 1));
  assign cmd_now   = mw_decode(op_q, addr_next[ADDR_W-1:ADDR_W-2]);
  assign rd_en     = last_addr && (cmd_now == CMD_READ);
  assign launch    = cs_fall && (st == ST_ARM);
  assign prog_cmd  = (cmd_q == CMD_WRITE) || (cmd_q == CMD_ERASE) ||
                     (cmd_q == CMD_WRAL)  || (cmd_q == CMD_ERAL);
  assign all_cmd   = (cmd_q == CMD_WRAL) || (cmd_q == CMD_ERAL);
  assign prog_go   = launch && prog_cmd && wen_q;

  // frame receiver
  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      bcnt    <= '0;
      op_q    <= '0;
      addr_sr <= '0;
      data_sr <= '0;
      cmd_q   <= CMD_NONE;
    end else if (!cs_q) begin
      st   <= ST_IDLE;
      bcnt <= '0;
    end else if (sk_rise) begin
      case (st)
        ST_IDLE: if (di_q && !busy) begin
          st   <= ST_OP;
          bcnt <= '0;
        end
        ST_OP: begin
          op_q <= {op_q[0], di_q};
          if (bcnt == CNT_W'(1)) begin
            st   <= ST_ADDR;
            bcnt <= '0;
          end else bcnt <= bcnt + 1'b1;
        end
        ST_ADDR: begin
          addr_sr <= addr_next;
          if (bcnt == CNT_W'(ADDR_W - 1)) begin
            bcnt  <= '0;
            cmd_q <= cmd_now;
            if (cmd_now == CMD_READ) st <= ST_READ;
            else if ((cmd_now == CMD_WRITE) || (cmd_now == CMD_WRAL)) st <= ST_DATA;
            else st <= ST_ARM;
          end else bcnt <= bcnt + 1'b1;
        end
        ST_DATA: begin
          data_sr <= {data_sr[WORD_W-2:0], di_q};
          if (bcnt == CNT_W'(WORD_W - 1)) st <= ST_ARM;
          else bcnt <= bcnt + 1'b1;
        end
        ST_ARM:  st <= ST_DROP;
        default: st <= st;
      endcase
    end
  end

  // enable latch, status report, fill word
  always_ff @(posedge clk) begin
    if (rst) begin
      wen_q     <= 1'b0;
      status_en <= 1'b0;
      fill_q    <= '0;
    end else begin
      if (launch && (cmd_q == CMD_EWEN)) wen_q <= 1'b1;
      if (launch && (cmd_q == CMD_EWDS)) wen_q <= 1'b0;
      if (prog_go) begin
        status_en <= 1'b1;
        fill_q    <= ((cmd_q == CMD_ERASE) || (cmd_q == CMD_ERAL)) ? '1 : data_sr;
      end
      if (cs_q && di_q && sk_rise) status_en <= 1'b0;
    end
  end

  mw_prog_timer #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(prog_go), .all_words(all_cmd),
    .addr_in(addr_sr), .busy(busy), .wr_en(mem_we), .wr_addr(mem_wa)
  );

  mw_mem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_wa), .wdata(fill_q),
    .re(rd_en), .raddr(addr_next), .rdata(mem_q)
  );

  // read shifter and data-out
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_load <= 1'b0;
      rd_sr   <= '0;
      dout    <= 1'b0;
    end else begin
      rd_load <= rd_en;
      if (rd_load) rd_sr <= mem_q;
      else if ((st == ST_READ) && sk_rise) rd_sr <= {rd_sr[WORD_W-2:0], 1'b0};

      if (!cs_q)                dout <= 1'b0;
      else if (last_addr)       dout <= 1'b0;
      else if (st == ST_READ) begin
        if (sk_rise) dout <= rd_sr[WORD_W-1];
      end
      else if (status_en)       dout <= ~busy;
      else                      dout <= 1'b0;
    end
  end
endmodule

// File: rtl/mw_eeprom_checker.sv
module mw_eeprom_checker
  import mw_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int PROG_CYCLES = 5000
) (
  input logic      clk,
  input logic      rst,
  input logic      cs_q,
  input logic      di_q,
  input logic      sk_rise,
  input logic      busy,
  input logic      wen_q,
  input logic      mem_we,
  input mw_state_e st,
  input logic      dout
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LEN   = (PROG_CYCLES > DEPTH) ? PROG_CYCLES : DEPTH;

  int run;
  always_ff @(posedge clk) begin
    if (rst)       run <= 0;
    else if (busy) run <= run + 1;
    else           run <= 0;
  end

  // R1: reset leaves latch clear, output low, idle
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!wen_q && !dout && !busy));

  // R2: no array write unless the latch is set
  a_r2_write_gated: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> wen_q);

  // R5: the interval lasts exactly LEN cycles
  a_r5_busy_len: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> (run == LEN));

  // R6: clearing edge outside a read leaves data-out low
  a_r6_status_clear: assert property (@(posedge clk) disable iff (rst)
    (cs_q && di_q && sk_rise && (st != ST_READ)) |=> ##1 !dout);

  // R9: no frame is received during the interval
  a_r9_busy_idle: assert property (@(posedge clk) disable iff (rst)
    busy |-> (st == ST_IDLE));

  // R12: data-out low when deselected
  a_r12_cs_low_out: assert property (@(posedge clk) disable iff (rst)
    !cs_q |=> !dout);
endmodule

bind mw_eeprom_slave mw_eeprom_checker #(
  .ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .cs_q(cs_q), .di_q(di_q), .sk_rise(sk_rise),
  .busy(busy), .wen_q(wen_q), .mem_we(mem_we), .st(st), .dout(dout)
);

// File: tb/mw_eeprom_slave_tb.sv
module mw_eeprom_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 7;
  localparam int WW = 16;
  localparam int PC = 1500;
  localparam int H  = 4;
  localparam logic [AW-1:0] A_EWEN = AW'(3) << (AW - 2);
  localparam logic [AW-1:0] A_EWDS = '0;
  localparam logic [AW-1:0] A_ERAL = AW'(2) << (AW - 2);
  localparam logic [AW-1:0] A_WRAL = (AW'(1) << (AW - 2)) | AW'(5'h15);
  localparam int NV = 4;
  // {address, data written = data expected back}
  localparam logic [AW+WW-1:0] VEC [NV] = '{
    {7'd0,   16'h0001}, {7'd127, 16'h8000},
    {7'd64,  16'hFFFE}, {7'd33,  16'h5A5A}
  };

  logic clk = 1'b0, rst = 1'b1, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic dout;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom_slave #(.ADDR_W(AW), .WORD_W(WW), .PROG_CYCLES(PC)) u_dut (
    .clk(clk), .rst(rst), .cs(cs), .sk(sk), .di(di), .dout(dout)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic o);
    di = b; clks(H); sk = 1'b1; clks(H); o = dout; sk = 1'b0;
  endtask

  task automatic sel();
    cs = 1'b1; clks(H);
  endtask

  task automatic desel();
    sk = 1'b0; clks(H); cs = 1'b0; di = 1'b0; clks(H);
  endtask

  task automatic frame(input logic [1:0] op, input logic [AW-1:0] a,
                       input bit with_data, input logic [WW-1:0] d, input bit extra);
    logic o;
    sel();
    bit_io(1'b1, o);
    for (int i = 1; i >= 0; i--) bit_io(op[i], o);
    for (int i = AW-1; i >= 0; i--) bit_io(a[i], o);
    if (with_data) for (int i = WW-1; i >= 0; i--) bit_io(d[i], o);
    if (extra) bit_io(1'b0, o);
    desel();
  endtask

  task automatic rd_body(input logic [AW-1:0] a, output logic [WW-1:0] w, output logic dummy);
    logic o;
    bit_io(1'b1, o); bit_io(1'b1, o); bit_io(1'b0, o);
    for (int i = AW-1; i >= 0; i--) bit_io(a[i], o);
    dummy = o;
    w = '0;
    for (int i = 0; i < WW; i++) begin
      bit_io(1'b0, o);
      w = {w[WW-2:0], o};
    end
  endtask

  task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [WW-1:0] exp);
    logic [WW-1:0] w; logic dm;
    sel(); rd_body(a, w, dm); desel();
    chk({tag, " dummy"}, 32'(dm), 32'd0);
    chk(tag, 32'(w), 32'(exp));
  endtask

  task automatic prog_wait(input string tag, input bit launched);
    sel(); clks(4);
    chk({tag, " busy"}, 32'(dout), 32'd0);
    clks(PC + 20);
    chk({tag, " done"}, 32'(dout), 32'(launched));
    cs = 1'b0; clks(H);
    chk("R12 cs low", 32'(dout), 32'd0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic o, dm;
    logic [WW-1:0] w;
    clks(5); rst = 1'b0; clks(3);
    chk("R1 reset dout", 32'(dout), 32'd0);

    // enable, whole-array erase
    frame(2'b00, A_EWEN, 0, '0, 0);
    frame(2'b00, A_ERAL, 0, '0, 0);
    prog_wait("R8 eral", 1);
    rd_chk("R8 eral word", 7'd5, 16'hFFFF);

    // disabled writes ignored; read works disabled
    frame(2'b00, A_EWDS, 0, '0, 0);
    frame(2'b01, 7'd5, 1, 16'h1234, 0);
    prog_wait("R2 write disabled", 0);
    rd_chk("R3 read while disabled", 7'd5, 16'hFFFF);
    frame(2'b11, 7'd5, 0, '0, 0);
    prog_wait("R2 erase disabled", 0);

    // reset clears the latch
    frame(2'b00, A_EWEN, 0, '0, 0);
    rst = 1'b1; clks(3); rst = 1'b0; clks(3);
    frame(2'b01, 7'd5, 1, 16'h1234, 0);
    prog_wait("R1 write after reset", 0);
    rd_chk("R1 word unchanged", 7'd5, 16'hFFFF);

    // vector table: write then read back
    frame(2'b00, A_EWEN, 0, '0, 0);
    for (int v = 0; v < NV; v++) begin
      frame(2'b01, VEC[v][AW+WW-1:WW], 1, VEC[v][WW-1:0], 0);
      prog_wait("R5 write", 1);
      rd_chk("R4 readback", VEC[v][AW+WW-1:WW], VEC[v][WW-1:0]);
    end

    // single erase
    frame(2'b11, 7'd33, 0, '0, 0);
    prog_wait("R8 erase", 1);
    rd_chk("R8 erased word", 7'd33, 16'hFFFF);
    rd_chk("R8 neighbour kept", 7'd0, 16'h0001);

    // whole-array write with junk address bits
    frame(2'b00, A_WRAL, 1, 16'hA5C3, 0);
    prog_wait("R7 wral", 1);
    rd_chk("R7 word 0", 7'd0, 16'hA5C3);
    rd_chk("R7 word 64", 7'd64, 16'hA5C3);
    rd_chk("R7 word 127", 7'd127, 16'hA5C3);
    rd_chk("R7 word 21", 7'd21, 16'hA5C3);

    // status clear alone
    frame(2'b01, 7'd12, 1, 16'h0BAD, 0);
    sel(); clks(PC + 20);
    chk("R5 ready", 32'(dout), 32'd1);
    bit_io(1'b1, o);
    chk("R6 status cleared", 32'(o), 32'd0);
    desel();

    // status clear and start bit on one edge
    frame(2'b01, 7'd13, 1, 16'hC0DE, 0);
    sel(); clks(PC + 20);
    chk("R6 ready before frame", 32'(dout), 32'd1);
    rd_body(7'd13, w, dm);
    desel();
    chk("R6 dummy", 32'(dm), 32'd0);
    chk("R6 start on clearing edge", 32'(w), 32'hC0DE);

    // frame during busy ignored
    frame(2'b01, 7'd9, 1, 16'h1111, 0);
    frame(2'b01, 7'd10, 1, 16'h2222, 0);
    clks(PC + 20);
    rd_chk("R9 busy frame ignored", 7'd10, 16'hA5C3);
    rd_chk("R9 first write kept", 7'd9, 16'h1111);

    // extra SK edge cancels
    frame(2'b01, 7'd11, 1, 16'h0F0F, 1);
    prog_wait("R10 extra edge", 0);
    rd_chk("R10 word unchanged", 7'd11, 16'hA5C3);

    // leading zeros before start bit
    sel();
    bit_io(1'b0, o); bit_io(1'b0, o);
    rd_body(7'd13, w, dm);
    desel();
    chk("R11 leading zeros", 32'(w), 32'hC0DE);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule